// File: doc/BRIEF.md
# Product Machine Equivalence Checker

This block decides whether two small Moore machines behave the same on every input sequence. A host loads both machines into internal tables. Each entry gives the next state for one state and one input symbol, a bit saying whether that transition is defined, and the output of the state. The host then pulses `start`.

The block searches the composite machine breadth-first. A composite state is a pair made of one state from each machine. The search begins at the pair of reset states (index 0 in both tables). It uses a work queue and a bitmap of pairs already seen, and it generates the edges of the pair graph only from pairs it actually reaches. A transition that is not defined, and any transition out of the reserved dead index, leads to that dead index.

The search stops at the first pair it takes from the queue whose outputs disagree. It then reports "not equivalent", the pair, and the number of symbols on the path that reached it. If the queue runs dry with no disagreement, it reports "equivalent".

Top module: `pm_equiv`

## Requirements
- R1: After reset, `busy`, `done` and `equiv` are all 0.
- R2: The search starts from pair (0,0). If the two state-0 outputs differ, the result is "not equivalent" with `fail_a`=0, `fail_b`=0 and `fail_len`=0.
- R3: The successor of pair (a,b) under symbol s is the pair of the two table successors under the same s. A transition whose valid bit is 0 goes to the dead index 2**SW-1. So does every transition out of the dead index.
- R4: A pair disagrees when exactly one of its states is the dead index, or when neither is dead and the two stored outputs differ. A pair whose states are both dead never disagrees.
- R5: `equiv`=1 is reported only after every pair reachable from (0,0) has been taken from the queue and none of them disagreed.
- R6: On a failure, `fail_len` is the length of the shortest symbol sequence that leads to a disagreeing pair. `fail_a` and `fail_b` give the first such pair the search meets. Pairs are expanded in queue order, and symbols in ascending order.
- R7: Each pair is queued at most once. One check keeps `busy` high for at most 2**(2*SW)*(NSYM+1)+1 cycles.
- R8: `done` is high for exactly one cycle. That is the first cycle in which `busy` is low after a check.
- R9: A `start` pulse that arrives while `busy` is high is ignored. No second check follows.
- R10: `equiv`, `fail_a`, `fail_b` and `fail_len` change only in a cycle in which `done` is high. Between checks they hold their values.
- R11: When `wr_en` is high in a cycle, the block writes `wr_next` and `wr_valid` into the entry for (`wr_mach`, `wr_state`, `wr_sym`), and `wr_out` into the output of (`wr_mach`, `wr_state`). `wr_mach`=0 selects machine A and `wr_mach`=1 selects machine B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_mach | input | 1 | Machine select: 0 = A, 1 = B |
| wr_state | input | SW | State row being written |
| wr_sym | input | $clog2(NSYM) | Input symbol column being written |
| wr_next | input | SW | Next-state index |
| wr_valid | input | 1 | 1 = transition defined |
| wr_out | input | OW | Output of the written state |
| start | input | 1 | Start a check (taken only when idle) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| equiv | output | 1 | 1 = machines equivalent |
| fail_a | output | SW | Machine A state of the disagreeing pair |
| fail_b | output | SW | Machine B state of the disagreeing pair |
| fail_len | output | 2*SW+1 | Path length, in symbols, to the disagreeing pair |

## Verification
The bound assertions check the following on every cycle:
- `done` is a single-cycle pulse that coincides with the fall of `busy`.
- A start during a search never launches a second search.
- The results hold between checks.
- A reported pair is never dead on both sides.
- A zero-length failure names pair (0,0).
- The search length stays within the pair-count bound.

Whether a verdict is right can only be shown by the bench's scenarios. These cover differently encoded but equivalent machines, one-sided and matched undefined transitions, a mismatch at the start pair, and a mismatch deep in a counter. The path length and pair reported for each depend on the table contents that scenario loads.

// File: rtl/pm_equiv.sv
module pm_equiv #(
  parameter int SW   = 3,
  parameter int NSYM = 4,
  parameter int OW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_mach,
  input  logic [SW-1:0]           wr_state,
  input  logic [$clog2(NSYM)-1:0] wr_sym,
  input  logic [SW-1:0]           wr_next,
  input  logic                    wr_valid,
  input  logic [OW-1:0]           wr_out,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    equiv,
  output logic [SW-1:0]           fail_a,
  output logic [SW-1:0]           fail_b,
  output logic [2*SW:0]           fail_len
);
  localparam int NS   = 1 << SW;
  localparam int SYMW = $clog2(NSYM);
  localparam int PW   = 2 * SW;
  localparam int NP   = 1 << PW;
  localparam int LW   = PW + 1;
  localparam int NT   = 2 * NS * NSYM;
  localparam int TIW  = $clog2(NT);
  localparam int QW   = PW + LW;
  localparam logic [SW-1:0] DEAD = SW'(NS - 1);

  typedef enum logic [1:0] {S_IDLE, S_POP, S_EXP} st_t;
  st_t st;

  logic [SW-1:0]   nxt_mem [NT];
  logic [NT-1:0]   vld_mem;
  logic [OW-1:0]   out_mem [2*NS];
  logic [QW-1:0]   q_mem   [NP];
  logic [NP-1:0]   visited;
  logic [PW-1:0]   head, tail;
  logic [PW:0]     cnt;
  logic [SW-1:0]   cur_a, cur_b;
  logic [LW-1:0]   cur_len;
  logic [SYMW-1:0] sym;

  function automatic logic [TIW-1:0] tidx(input logic m, input logic [SW-1:0] s,
                                          input logic [SYMW-1:0] y);
    return TIW'((int'(m) * NS + int'(s)) * NSYM + int'(y));
  endfunction

  logic [TIW-1:0] wi, ia, ib;
  logic [SW-1:0]  nxt_a, nxt_b, ha, hb;
  logic [LW-1:0]  hl;
  logic           mism, start_go, enq;
  logic [QW-1:0]  enq_data;

  assign wi = tidx(wr_mach, wr_state, wr_sym);
  assign ia = tidx(1'b0, cur_a, sym);
  assign ib = tidx(1'b1, cur_b, sym);
  assign nxt_a = (cur_a == DEAD || !vld_mem[ia]) ? DEAD : nxt_mem[ia];
  assign nxt_b = (cur_b == DEAD || !vld_mem[ib]) ? DEAD : nxt_mem[ib];

  assign {ha, hb, hl} = q_mem[head];
  assign mism = ((ha == DEAD) != (hb == DEAD)) ||
                ((ha != DEAD) && (hb != DEAD) && (out_mem[{1'b0, ha}] != out_mem[{1'b1, hb}]));

  assign start_go = start && (st == S_IDLE);
  assign enq      = start_go || (st == S_EXP && !visited[{nxt_a, nxt_b}]);
  assign enq_data = start_go ? '0 : {nxt_a, nxt_b, cur_len + LW'(1)};
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (wr_en) nxt_mem[wi] <= wr_next;
    if (enq) q_mem[start_go ? '0 : tail] <= enq_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_mem <= '0;
      for (int k = 0; k < 2*NS; k++) out_mem[k] <= '0;
    end else if (wr_en) begin
      vld_mem[wi] <= wr_valid;
      out_mem[{wr_mach, wr_state}] <= wr_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      visited  <= '0;
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      cur_a    <= '0;
      cur_b    <= '0;
      cur_len  <= '0;
      sym      <= '0;
      done     <= 1'b0;
      equiv    <= 1'b0;
      fail_a   <= '0;
      fail_b   <= '0;
      fail_len <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          visited <= NP'(1);
          head    <= '0;
          tail    <= PW'(1);
          cnt     <= (PW+1)'(1);
          st      <= S_POP;
        end
        S_POP: begin
          if (cnt == '0) begin
            done     <= 1'b1;
            equiv    <= 1'b1;
            fail_a   <= '0;
            fail_b   <= '0;
            fail_len <= '0;
            st       <= S_IDLE;
          end else begin
            head <= head + PW'(1);
            cnt  <= cnt - (PW+1)'(1);
            if (mism) begin
              done     <= 1'b1;
              equiv    <= 1'b0;
              fail_a   <= ha;
              fail_b   <= hb;
              fail_len <= hl;
              st       <= S_IDLE;
            end else begin
              cur_a   <= ha;
              cur_b   <= hb;
              cur_len <= hl;
              sym     <= '0;
              st      <= S_EXP;
            end
          end
        end
        S_EXP: begin
          if (enq) begin
            visited[{nxt_a, nxt_b}] <= 1'b1;
            tail <= tail + PW'(1);
            cnt  <= cnt + (PW+1)'(1);
          end
          if (int'(sym) == NSYM - 1) st <= S_POP;
          else sym <= sym + SYMW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pm_equiv_chk.sv
module pm_equiv_chk #(
  parameter int SW   = 3,
  parameter int NSYM = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          equiv,
  input logic [SW-1:0] fail_a,
  input logic [SW-1:0] fail_b,
  input logic [2*SW:0] fail_len
);
  localparam int LIMIT = (1 << (2*SW)) * (NSYM + 1) + 1;
  localparam logic [SW-1:0] DEAD = SW'((1 << SW) - 1);

  int run_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cyc <= 0;
    else if (busy) run_cyc <= run_cyc + 1;
    else run_cyc <= 0;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r8_fall_done:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n) busy && start |=> busy || done);
  a_r10_hold:      assert property (@(posedge clk) disable iff (!rst_n)
                     !done |-> $stable(equiv) && $stable(fail_a) && $stable(fail_b) && $stable(fail_len));
  a_r4_not_both_dead: assert property (@(posedge clk) disable iff (!rst_n)
                     done && !equiv |-> !(fail_a == DEAD && fail_b == DEAD));
  a_r2_start_pair: assert property (@(posedge clk) disable iff (!rst_n)
                     done && !equiv && fail_len == '0 |-> fail_a == '0 && fail_b == '0);
  a_r7_bound:      assert property (@(posedge clk) disable iff (!rst_n) run_cyc <= LIMIT);
endmodule

bind pm_equiv pm_equiv_chk #(.SW(SW), .NSYM(NSYM)) u_pm_equiv_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .equiv(equiv), .fail_a(fail_a), .fail_b(fail_b), .fail_len(fail_len)
);

// File: tb/test_pm_equiv.sv
module test_pm_equiv;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_mach = 0, wr_valid = 0, start = 0;
  logic [2:0] wr_state = 0, wr_next = 0;
  logic [1:0] wr_sym = 0, wr_out = 0;
  logic       busy, done, equiv;
  logic [2:0] fail_a, fail_b;
  logic [6:0] fail_len;

  int nchk = 0, nfail = 0;
  localparam int LIMIT = 64 * 5 + 1;

  always #5 clk = ~clk;

  pm_equiv i_pm_equiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mach(wr_mach), .wr_state(wr_state),
    .wr_sym(wr_sym), .wr_next(wr_next), .wr_valid(wr_valid), .wr_out(wr_out),
    .start(start), .busy(busy), .done(done), .equiv(equiv),
    .fail_a(fail_a), .fail_b(fail_b), .fail_len(fail_len)
  );

  typedef struct packed {
    logic [1:0] op;
    logic       m;
    logic [2:0] s;
    logic [1:0] y;
    logic [2:0] n;
    logic       v;
    logic [1:0] o;
    logic       eq;
    logic [2:0] ea;
    logic [2:0] eb;
    logic [6:0] ln;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,1,1,0,0,0,0,0}, '{0,0,0,1,0,1,0,0,0,0,0},
    '{0,0,1,0,0,1,1,0,0,0,0}, '{0,0,1,1,1,1,1,0,0,0,0},
    '{0,1,0,0,2,1,0,0,0,0,0}, '{0,1,0,1,0,1,0,0,0,0,0},
    '{0,1,2,0,5,1,1,0,0,0,0}, '{0,1,2,1,2,1,1,0,0,0,0},
    '{0,1,5,0,2,1,0,0,0,0,0}, '{0,1,5,1,5,1,0,0,0,0,0},
    '{1,0,0,0,0,0,0,1,0,0,0},
    '{0,1,5,0,2,1,1,0,0,0,0}, '{0,1,5,1,5,1,1,0,0,0,0},
    '{1,0,0,0,0,0,0,0,0,5,2},
    '{0,1,5,0,2,1,0,0,0,0,0}, '{0,1,5,1,5,1,0,0,0,0,0},
    '{0,0,1,1,1,0,1,0,0,0,0},
    '{1,0,0,0,0,0,0,0,7,2,2},
    '{0,1,2,1,2,0,1,0,0,0,0},
    '{1,0,0,0,0,0,0,1,0,0,0},
    '{0,0,0,0,1,1,3,0,0,0,0},
    '{1,0,0,0,0,0,0,0,0,0,0},
    '{2,0,0,0,0,0,0,0,0,0,0},
    '{1,0,0,0,0,0,0,1,0,0,0},
    '{0,0,0,3,1,1,0,0,0,0,0}, '{0,0,1,3,2,1,0,0,0,0,0},
    '{0,0,2,3,3,1,0,0,0,0,0}, '{0,0,3,3,0,1,1,0,0,0,0},
    '{0,1,0,3,1,1,0,0,0,0,0}, '{0,1,1,3,2,1,0,0,0,0,0},
    '{0,1,2,3,3,1,0,0,0,0,0}, '{0,1,3,3,0,1,0,0,0,0,0},
    '{1,0,0,0,0,0,0,0,3,3,3},
    '{0,1,3,3,0,1,1,0,0,0,0},
    '{1,0,0,0,0,0,0,1,0,0,0},
    '{1,0,0,0,0,0,0,1,0,0,0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input vec_t v);
    @(negedge clk);
    wr_en = 1; wr_mach = v.m; wr_state = v.s; wr_sym = v.y;
    wr_next = v.n; wr_valid = v.v; wr_out = v.o;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 equiv", equiv, 0);
    rst_n = 1;

    // R11 loads, R2/R3/R4/R5/R6 verdicts
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].op == 2'd0) wr(VEC[k]);
      else if (VEC[k].op == 2'd2) do_reset();
      else begin
        run(cyc);
        chk("R8 done seen", done, 1);
        chk("R5 verdict", equiv, VEC[k].eq);
        if (!VEC[k].eq) begin
          chk("R3/R4/R6 fail_a", fail_a, VEC[k].ea);
          chk("R3/R4/R6 fail_b", fail_b, VEC[k].eb);
          chk("R2/R6 fail_len", fail_len, VEC[k].ln);
        end
        chk("R7 cycle bound", int'(cyc <= LIMIT), 1);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
      end
    end

    // R9: start while busy ignored
    begin
      int c2;
      @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (2) @(negedge clk);
      chk("R9 busy mid-run", busy, 1);
      start = 1;
      @(negedge clk);
      start = 0;
      c2 = 0;
      while (!done && c2 < 2000) begin
        @(negedge clk);
        c2++;
      end
      chk("R9 verdict", equiv, 1);
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        chk("R9 no second run", busy, 0);
        chk("R10 equiv held", equiv, 1);
      end
    end

    // R1: reset during a search
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 equiv after reset", equiv, 0);
    rst_n = 1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule